// File: doc/BRIEF.md
# Calendar Snapshot Transfer Sequencer

This block reads or sets a complete date and time held in a clock chip. The chip stores each decimal digit in its own 4-bit register. The block does not move serial bits itself. A serial master below it carries one register operation at a time: a 4-bit address, a direction, and a 4-bit value in or out. The block issues those operations in a fixed order and drives the chip-enable line around them.

A transfer always begins with a handshake. The block raises chip enable, writes the 24-hour mode value into the control register, and reads that register back. While bit 0 of the read-back (the clock's update-in-progress flag) is set, the block drops chip enable for one phase and tries again. If the flag never clears, the transfer ends with an error.

Once the flag is clear, a read collects the thirteen digit registers and packs each pair into a BCD byte. Those bytes reach the output registers only when the transfer ends, so a consumer never sees a partly updated time. A write sends every byte of a captured time as two nibbles. Values stay in BCD throughout.

Top module: `cal_snapshot_seq`

## Requirements
- R1: While reset is held and directly after it, `ce`, `op_req`, `done`, `timeout_err` and `seq_busy` are 0, and every time output is zero.
- R2: Each attempt raises `ce`, then writes value 0x4 to register 0xE (`op_we`=1), then reads register 0xE (`op_we`=0).
- R3: If bit 0 of the register 0xE read-back is 1, the block lowers `ce` for at least `PHASE_CYC` cycles and then starts a new attempt. A transfer that sees the flag set on 101 attempts in a row still completes with `timeout_err`=0.
- R4: If the flag is seen on attempt `MAX_RETRY`+2 (102 by default), the block issues no digit operations. It ends with `done` and `timeout_err`=1, and the time outputs keep their earlier values. `timeout_err` stays 1 until the next start.
- R5: After the handshake, a read visits these addresses in this order: 0x0, 0x1, 0x2, 0x3, 0x4, 0x5, 0x8, 0x9, 0xA, 0xB, 0xC, 0xD, 0x6. The order is seconds, minutes, hours, day, month and year, units before tens, then the weekday.
- R6: Each read byte is the tens nibble (from the odd address) in bits 7:4 and the units nibble (from the even address) in bits 3:0. The weekday is the single nibble read from 0x6.
- R7: A write uses the address order of R5. It sends bits 3:0 of each input byte to the even address, then bits 7:4 to the odd address, then the weekday nibble to 0x6. All of these values are captured at the start.
- R8: After the last operation, `ce` goes low and stays low for at least `PHASE_CYC` cycles before `done` rises. `done` is a one-cycle pulse.
- R9: The time outputs change only in the cycle in which `done` is 1, and only at the end of a read that did not time out.
- R10: `op_req` stays high with its address, direction and data unchanged until `op_ack`. `ce` is 1 whenever `op_req` is 1.
- R11: A start pulse that arrives while `seq_busy` is 1 has no effect. If `rd_start` and `wr_start` arrive in the same cycle, a read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | Pulse: read the full time |
| wr_start | input | 1 | Pulse: write the full time |
| wr_sec | input | 8 | BCD seconds to write |
| wr_min | input | 8 | BCD minutes to write |
| wr_hour | input | 8 | BCD hours to write |
| wr_day | input | 8 | BCD day of month to write |
| wr_mon | input | 8 | BCD month to write |
| wr_year | input | 8 | BCD year to write |
| wr_wday | input | 4 | Weekday nibble to write |
| rd_sec | output | 8 | BCD seconds from the last good read |
| rd_min | output | 8 | BCD minutes from the last good read |
| rd_hour | output | 8 | BCD hours from the last good read |
| rd_day | output | 8 | BCD day from the last good read |
| rd_mon | output | 8 | BCD month from the last good read |
| rd_year | output | 8 | BCD year from the last good read |
| rd_wday | output | 4 | Weekday from the last good read |
| seq_busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| timeout_err | output | 1 | The last transfer gave up on the busy flag |
| ce | output | 1 | Chip enable to the clock chip |
| op_req | output | 1 | Register operation request to the serial master |
| op_we | output | 1 | 1 = write operation, 0 = read operation |
| op_addr | output | 4 | Register address |
| op_wdata | output | 4 | Nibble to write |
| op_ack | input | 1 | Serial master completed the operation |
| op_rdata | input | 4 | Nibble read, valid with op_ack |

## Verification
The hardest point to reach from the ports is the exact edge of the retry limit. To get there, the busy flag must stay set for exactly 101 polls in one transfer and exactly 102 in another. The bench's register model holds a countdown of busy replies, so each of these lengths is set precisely. The model also logs every operation, along with the state of chip enable when it happened. That log lets the bench check the handshake pairs, the digit order and the absence of digit traffic after a timeout. A second situation is a start pulse arriving in the middle of a transfer. The bench raises it there deliberately, and it also compares the outputs mid-transfer with their old values.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
   localparam int unsigned NSTEP  = 13;
   localparam int unsigned NFIELD = 6;
   localparam logic [3:0]  CTRL_ADDR   = 4'hE;
   localparam logic [3:0]  CTRL_MODE24 = 4'h4;
   localparam logic [3:0]  WDAY_ADDR   = 4'h6;

   typedef enum logic [2:0] {
      S_IDLE, S_MODE, S_POLL, S_RGAP, S_XFER, S_EGAP
   } seq_state_t;
endpackage

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
   parameter int unsigned PHASE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int unsigned W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

   if (PHASE_CYC < 1) begin : g_bad_phase
      $error("PHASE_CYC must be at least 1");
   end

   logic [W-1:0] cnt;

   assign expire = run && (cnt == W'(PHASE_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (!run || expire)  cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

   AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < PHASE_CYC); // R3
endmodule

// File: rtl/cal_attempt_ctr.sv
module cal_attempt_ctr #(
   parameter int unsigned LIMIT = 101
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int unsigned W = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least 1");
   end

   logic [W-1:0] cnt;

   assign last = (cnt == W'(LIMIT));

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (inc)   cnt <= cnt + 1'b1;
   end

   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= LIMIT); // R4
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> !last); // R4
endmodule

// File: rtl/cal_step_map.sv
module cal_step_map
   import cal_seq_pkg::*;
(
   input  logic [3:0] step,
   output logic [3:0] addr,
   output logic       last
);
   logic [2:0] fld;
   logic [3:0] base;

   always_comb begin
      fld  = step[3:1];
      base = (fld < 3'd3) ? {fld, 1'b0} : {fld + 3'd1, 1'b0};
      last = (step == 4'(NSTEP - 1));
      addr = last ? WDAY_ADDR : (base | {3'b000, step[0]});
   end
endmodule

// File: rtl/cal_snapshot_seq.sv
module cal_snapshot_seq
   import cal_seq_pkg::*;
#(
   parameter int unsigned PHASE_CYC = 4,
   parameter int unsigned MAX_RETRY = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_start,
   input  logic       wr_start,
   input  logic [7:0] wr_sec,
   input  logic [7:0] wr_min,
   input  logic [7:0] wr_hour,
   input  logic [7:0] wr_day,
   input  logic [7:0] wr_mon,
   input  logic [7:0] wr_year,
   input  logic [3:0] wr_wday,
   output logic [7:0] rd_sec,
   output logic [7:0] rd_min,
   output logic [7:0] rd_hour,
   output logic [7:0] rd_day,
   output logic [7:0] rd_mon,
   output logic [7:0] rd_year,
   output logic [3:0] rd_wday,
   output logic       seq_busy,
   output logic       done,
   output logic       timeout_err,
   output logic       ce,
   output logic       op_req,
   output logic       op_we,
   output logic [3:0] op_addr,
   output logic [3:0] op_wdata,
   input  logic       op_ack,
   input  logic [3:0] op_rdata
);
   localparam int unsigned ATT_LIMIT = MAX_RETRY + 1;

   if (MAX_RETRY < 1) begin : g_bad_retry
      $error("MAX_RETRY must be at least 1");
   end

   seq_state_t st;
   logic       is_wr;
   logic       tout;
   logic [3:0] step;
   logic       start_any;
   logic       gap_run, gap_done;
   logic       att_inc, att_clr, att_last;
   logic [3:0] map_addr;
   logic       map_last;
   logic [7:0] wr_f  [NFIELD];
   logic [3:0] nib_w [NSTEP];
   logic [7:0] out_q [NFIELD];
   logic [3:0] out_wday;

   assign start_any = rd_start | wr_start;

   assign wr_f[0] = wr_sec;
   assign wr_f[1] = wr_min;
   assign wr_f[2] = wr_hour;
   assign wr_f[3] = wr_day;
   assign wr_f[4] = wr_mon;
   assign wr_f[5] = wr_year;

   // per-digit storage: loaded from the inputs on a write start,
   // filled from op_rdata during a read
   for (genvar g = 0; g < NSTEP; g++) begin : g_nib
      logic [3:0] q;
      logic [3:0] ld;
      if (g == NSTEP - 1) begin : g_wd
         assign ld = wr_wday;
      end else if ((g % 2) == 1) begin : g_tens
         assign ld = wr_f[g / 2][7:4];
      end else begin : g_units
         assign ld = wr_f[g / 2][3:0];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (st == S_IDLE && start_any)
            q <= ld;
         else if (st == S_XFER && op_ack && !is_wr && step == 4'(g))
            q <= op_rdata;
      end
      assign nib_w[g] = q;
   end

   cal_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (gap_run),
      .expire(gap_done)
   );

   cal_attempt_ctr #(.LIMIT(ATT_LIMIT)) u_att (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (att_clr),
      .inc  (att_inc),
      .last (att_last)
   );

   cal_step_map u_map (
      .step(step),
      .addr(map_addr),
      .last(map_last)
   );

   assign gap_run = (st == S_RGAP) || (st == S_EGAP);
   assign att_clr = (st == S_IDLE);
   assign att_inc = (st == S_POLL) && op_ack && op_rdata[0] && !att_last;

   always_comb begin
      op_req   = (st == S_MODE) || (st == S_POLL) || (st == S_XFER);
      op_we    = (st == S_MODE) || ((st == S_XFER) && is_wr);
      op_addr  = (st == S_XFER) ? map_addr : CTRL_ADDR;
      op_wdata = '0;
      if (st == S_MODE)
         op_wdata = CTRL_MODE24;
      else if (st == S_XFER && is_wr)
         op_wdata = nib_w[step];
   end

   assign ce       = op_req;
   assign seq_busy = (st != S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         is_wr       <= 1'b0;
         tout        <= 1'b0;
         step        <= '0;
         done        <= 1'b0;
         timeout_err <= 1'b0;
         out_wday    <= '0;
         for (int i = 0; i < NFIELD; i++) out_q[i] <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (start_any) begin
               st          <= S_MODE;
               is_wr       <= !rd_start;
               tout        <= 1'b0;
               timeout_err <= 1'b0;
            end
            S_MODE: if (op_ack) st <= S_POLL;
            S_POLL: if (op_ack) begin
               if (!op_rdata[0]) begin
                  step <= '0;
                  st   <= S_XFER;
               end else if (att_last) begin
                  tout <= 1'b1;
                  st   <= S_EGAP;
               end else begin
                  st   <= S_RGAP;
               end
            end
            S_RGAP: if (gap_done) st <= S_MODE;
            S_XFER: if (op_ack) begin
               if (map_last) st <= S_EGAP;
               else          step <= step + 1'b1;
            end
            S_EGAP: if (gap_done) begin
               st          <= S_IDLE;
               done        <= 1'b1;
               timeout_err <= tout;
               if (!is_wr && !tout) begin
                  for (int i = 0; i < NFIELD; i++)
                     out_q[i] <= {nib_w[2*i+1], nib_w[2*i]};
                  out_wday <= nib_w[NSTEP-1];
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign rd_sec  = out_q[0];
   assign rd_min  = out_q[1];
   assign rd_hour = out_q[2];
   assign rd_day  = out_q[3];
   assign rd_mon  = out_q[4];
   assign rd_year = out_q[5];
   assign rd_wday = out_wday;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req && !op_ack) |=> (op_req && $stable(op_addr) && $stable(op_we)
                               && $stable(op_wdata))); // R10
   AST_DONE_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ce && !op_req && !$past(ce))); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_TOUT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_err) |-> done); // R4
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year,
                         rd_wday})); // R9
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && start_any) |=> $stable(is_wr)); // R11
endmodule

// File: tb/sim_cal_snapshot_seq.sv
module sim_cal_snapshot_seq;
   localparam int P  = 4;
   localparam int MR = 100;
   localparam logic [3:0] EXP_ADDR [13] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5,
                                           4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'h6};
   // {write, busy polls, ack latency, sec, min, hour, day, mon, year, wday}
   localparam logic [64:0] VEC [6] = '{
      {1'b0, 8'd0,   4'd0, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 4'h6},
      {1'b1, 8'd0,   4'd1, 8'h45, 8'h07, 8'h13, 8'h28, 8'h02, 8'h24, 4'h3},
      {1'b0, 8'd3,   4'd2, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 4'h0},
      {1'b1, 8'd2,   4'd0, 8'h12, 8'h34, 8'h05, 8'h09, 8'h11, 8'h70, 4'h5},
      {1'b0, 8'd1,   4'd3, 8'h07, 8'h48, 8'h19, 8'h22, 8'h10, 8'h05, 4'h1},
      {1'b0, 8'd101, 4'd0, 8'h30, 8'h15, 8'h08, 8'h17, 8'h06, 8'h38, 4'h2}
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       rd_start = 1'b0, wr_start = 1'b0;
   logic [7:0] wr_sec = '0, wr_min = '0, wr_hour = '0, wr_day = '0, wr_mon = '0, wr_year = '0;
   logic [3:0] wr_wday = '0;
   logic [7:0] rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year;
   logic [3:0] rd_wday;
   logic       seq_busy, done, timeout_err, ce, op_req, op_we;
   logic [3:0] op_addr, op_wdata;
   logic       op_ack = 1'b0;
   logic [3:0] op_rdata = '0;

   cal_snapshot_seq #(.PHASE_CYC(P), .MAX_RETRY(MR)) u0 (
      .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .wr_start(wr_start),
      .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_day(wr_day),
      .wr_mon(wr_mon), .wr_year(wr_year), .wr_wday(wr_wday),
      .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_day(rd_day),
      .rd_mon(rd_mon), .rd_year(rd_year), .rd_wday(rd_wday),
      .seq_busy(seq_busy), .done(done), .timeout_err(timeout_err), .ce(ce),
      .op_req(op_req), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
      .op_ack(op_ack), .op_rdata(op_rdata)
   );

   int total = 0, bad = 0;

   // register model of the clock chip with an operation log
   logic [3:0] mem [16];
   int busy_left = 0, lat = 0, wcnt = 0, nlog = 0;
   logic [3:0] la [512];
   logic [3:0] ldat [512];
   logic       lw [512];
   logic       lc [512];

   always @(negedge clk) begin
      if (!rst_n) begin
         op_ack = 1'b0;
         wcnt   = 0;
      end else if (op_ack) begin
         op_ack = 1'b0;
         wcnt   = 0;
      end else if (op_req) begin
         if (wcnt >= lat) begin
            if (nlog < 512) begin
               la[nlog] = op_addr; ldat[nlog] = op_wdata;
               lw[nlog] = op_we;   lc[nlog]   = ce;
            end
            nlog++;
            if (op_we) mem[op_addr] = op_wdata;
            else if (op_addr == 4'hE) begin
               op_rdata = {mem[14][3:1], busy_left > 0};
               if (busy_left > 0) busy_left--;
            end else op_rdata = mem[op_addr];
            op_ack = 1'b1;
         end else wcnt++;
      end
   end

   // chip-enable monitor
   logic ce_prev = 1'b0;
   int rises = 0, low_run = 0, gap_min = 1000;
   always @(negedge clk) begin
      if (ce && !ce_prev) begin
         if (rises > 0 && low_run < gap_min) gap_min = low_run;
         rises++;
      end
      if (ce) low_run = 0; else low_run++;
      ce_prev = ce;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] nib_of(input logic [64:0] v, input int i);
      logic [7:0] b;
      if (i == 12) return v[3:0];
      b = v[51 - 8*(i/2) -: 8];
      return (i % 2 == 1) ? b[7:4] : b[3:0];
   endfunction

   function automatic logic [51:0] outs();
      return {rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year, rd_wday};
   endfunction

   task automatic set_wr(input logic [51:0] f);
      {wr_sec, wr_min, wr_hour, wr_day, wr_mon, wr_year, wr_wday} = f;
   endtask

   task automatic clear_mon();
      nlog = 0; rises = 0; gap_min = 1000;
   endtask

   task automatic launch(input logic rd, input logic wr);
      @(negedge clk); #1;
      rd_start = rd; wr_start = wr;
      @(negedge clk); #1;
      rd_start = 1'b0; wr_start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (1) begin
         @(negedge clk); #1;
         if (done) break;
         n++;
         if (n > 30000) begin
            chk("watchdog R8", 64'd0, 64'd1);
            break;
         end
      end
   endtask

   task automatic run_vec(input logic [64:0] v);
      int b, nb;
      logic wr;
      logic [51:0] old;
      b  = int'(v[63:56]);
      wr = v[64];
      lat = int'(v[55:52]);
      busy_left = b;
      for (int i = 0; i < 16; i++) mem[i] = 4'h0;
      if (!wr) begin
         for (int i = 0; i < 13; i++) mem[EXP_ADDR[i]] = nib_of(v, i);
         set_wr(~v[51:0]);
      end else set_wr(v[51:0]);
      old = outs();
      clear_mon();
      launch(!wr, wr);
      wait_done();
      chk("R3 no timeout", 64'(timeout_err), 64'd0);
      chk("R3 op count", 64'(nlog), 64'(2*(b+1)+13));
      chk("R3 ce attempts", 64'(rises), 64'(b+1));
      if (b > 0) chk("R3 retry gap", 64'(gap_min >= P), 64'd1);
      chk("R8 end gap", 64'(low_run >= P), 64'd1);
      nb = 0;
      for (int k = 0; k < b+1; k++) begin
         if (!(lw[2*k] && la[2*k] == 4'hE && ldat[2*k] == 4'h4)) nb++;
         if (!(!lw[2*k+1] && la[2*k+1] == 4'hE)) nb++;
      end
      chk("R2 handshake", 64'(nb), 64'd0);
      nb = 0;
      for (int i = 0; i < 13; i++) begin
         int e = 2*(b+1) + i;
         if (la[e] != EXP_ADDR[i] || lw[e] != wr || (wr && ldat[e] != nib_of(v, i))) nb++;
      end
      chk(wr ? "R7 write order/data" : "R5 read order", 64'(nb), 64'd0);
      nb = 0;
      for (int i = 0; i < nlog && i < 512; i++) if (!lc[i]) nb++;
      chk("R10 ce during op", 64'(nb), 64'd0);
      if (!wr) chk("R6 packed outputs", 64'(outs()), 64'(v[51:0]));
      else begin
         chk("R9 outputs kept on write", 64'(outs()), 64'(old));
         nb = 0;
         for (int i = 0; i < 13; i++) if (mem[EXP_ADDR[i]] != nib_of(v, i)) nb++;
         chk("R7 chip contents", 64'(nb), 64'd0);
      end
      @(negedge clk); #1;
      chk("R8 done pulse", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [51:0] old;
      int nb;
      for (int i = 0; i < 16; i++) mem[i] = 4'h0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset ce/req", 64'({ce, op_req}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 idle flags", 64'({done, timeout_err, seq_busy, ce, op_req}), 64'd0);
      chk("R1 outputs zero", 64'(outs()), 64'd0);

      for (int t = 0; t < 6; t++) run_vec(VEC[t]);

      // timeout boundary: busy on 102 attempts
      old = outs();
      lat = 0; busy_left = 102;
      clear_mon();
      launch(1'b1, 1'b0);
      wait_done();
      chk("R4 timeout flag", 64'(timeout_err), 64'd1);
      chk("R4 op count", 64'(nlog), 64'd204);
      nb = 0;
      for (int i = 0; i < nlog && i < 512; i++) if (la[i] != 4'hE) nb++;
      chk("R4 no digit ops", 64'(nb), 64'd0);
      chk("R4 outputs kept", 64'(outs()), 64'(old));
      repeat (3) @(negedge clk); #1;
      chk("R4 error held", 64'(timeout_err), 64'd1);
      run_vec(VEC[0]);

      // start while busy is ignored; outputs unchanged mid-transfer
      for (int i = 0; i < 16; i++) mem[i] = 4'h0;
      for (int i = 0; i < 13; i++) mem[EXP_ADDR[i]] = nib_of(VEC[4], i);
      old = outs();
      lat = 2; busy_left = 3;
      clear_mon();
      launch(1'b1, 1'b0);
      repeat (8) @(negedge clk); #1;
      chk("R9 mid-transfer outputs", 64'(outs()), 64'(old));
      set_wr(52'h1234567890abc);
      wr_start = 1'b1; rd_start = 1'b1;
      @(negedge clk); #1;
      wr_start = 1'b0; rd_start = 1'b0;
      wait_done();
      chk("R11 ignored start count", 64'(nlog), 64'd21);
      nb = 0;
      for (int i = 8; i < nlog && i < 512; i++) if (lw[i]) nb++;
      chk("R11 no writes", 64'(nb), 64'd0);
      chk("R11 read result", 64'(outs()), 64'(VEC[4][51:0]));
      repeat (2) @(negedge clk); #1;
      chk("R11 stays idle", 64'(seq_busy), 64'd0);

      // both starts together: read wins
      for (int i = 0; i < 13; i++) mem[EXP_ADDR[i]] = nib_of(VEC[2], i);
      lat = 0; busy_left = 0;
      clear_mon();
      launch(1'b1, 1'b1);
      wait_done();
      nb = 0;
      for (int i = 2; i < nlog && i < 512; i++) if (lw[i]) nb++;
      chk("R11 read priority", 64'(nb), 64'd0);
      chk("R11 read priority data", 64'(outs()), 64'(VEC[2][51:0]));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule